// File: doc/BRIEF.md
# PCI Interrupt Map and Gate

This block sits between 32 level-sensitive PCI interrupt request lines and the interrupt controller. The lines are split into eight groups of four, and each group has one map register. The top bit of a map register is a software-writable enable. Bits 30 to 0 hold a fixed routing code that software can read but never change. While a group is enabled, its four request levels pass straight through to the matching outputs. While a group is disabled, those four outputs are forced low whatever the inputs do.

Software reaches the map registers over a 32-bit register bus. Each access is a one-cycle strobe. The registers sit 8 bytes apart inside a 64-byte window, and only the upper 32-bit word of each slot holds storage. Read data is registered.

There are two resets. The asynchronous power-on reset puts the block in its initial state. The synchronous device reset clears every enable and leaves the routing codes alone.

Top module: `irq_map_gate`

## Requirements
- R1: After power-on reset, every enable bit is 0 and all 32 outputs are low for any input pattern.
- R2: The live word of map register g holds bit 31 = enable and bits [30:0] = (0x1F << 6) | (g << 2).
- R3: `regRdata` is valid in the cycle after the read strobe. Back-to-back reads return their values in issue order, one per cycle.
- R4: A write to a live word changes only bit 31, setting it to `regWdata[31]`. Bits [30:0] read back unchanged whatever `regWdata[30:0]` holds.
- R5: Map register g is decoded at byte offset `BASE_ADDR + 8*g + 4`, where g is `regAddr[5:3]` and `regAddr[2]` = 1 selects the live word. The lower word of each slot (`regAddr[2]` = 0) reads as zero, and a write to it changes no enable.
- R6: An offset outside `BASE_ADDR` to `BASE_ADDR + 0x3F` (default base 0xC00) reads as zero, and a write to it changes no enable.
- R7: Input n is controlled by map register n >> 2. While that enable is 1, output n equals input n.
- R8: While the controlling enable is 0, output n is low whatever input n does.
- R9: A device reset pulse clears all enables by the next cycle and leaves every routing code intact. It takes priority over a write in the same cycle.
- R10: A change to an enable reaches the outputs in the cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| softRst | input | 1 | Synchronous device reset that clears all enables |
| regSel | input | 1 | One-cycle access strobe |
| regWr | input | 1 | 1 = write, 0 = read, qualified by regSel |
| regAddr | input | 16 | Byte offset of the access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Registered read data |
| irqIn | input | 32 | Level interrupt requests |
| irqOut | output | 32 | Gated interrupt requests |

## Verification
The assertions assume these things about the inputs:
- `regSel`, `regWr`, `regAddr` and `regWdata` are driven to known values and held steady across the sampling edge.
- `softRst` is synchronous to `clk`.
- Addresses are word aligned, so bits [1:0] carry no meaning.

The stimulus meets these assumptions by changing every input only on the falling edge and always driving `regAddr[1:0]` to zero. It also issues device reset only between accesses. The one exception is a single deliberate collision with a write, used to check the priority rule of R9.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;

  localparam int GRP_CNT   = 8;
  localparam int GRP_IDX_W = $clog2(GRP_CNT);
  localparam logic [4:0] ROUTE_PRIO = 5'h1F;

  // Strobes from decode to the register/gate datapath
  typedef struct packed {
    logic                 wrHi;    // write to the live word of a map register
    logic                 rdLive;  // read of the live word
    logic                 rdZero;  // read that must return zero
    logic [GRP_IDX_W-1:0] idx;     // map register index
  } mapStrb_t;

  // Fixed routing code held in bits [30:0] of register g
  function automatic logic [30:0] routeCode(input logic [GRP_IDX_W-1:0] g);
    routeCode = (31'(ROUTE_PRIO) << 6) | (31'(g) << 2);
  endfunction

endpackage

// File: rtl/irqmap_ctrl.sv
module irqmap_ctrl
  import irqmap_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0C00
) (
  input  logic              regSel,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output mapStrb_t          strb
);

  // 8-byte stride: index sits above bit 2, window spans GRP_CNT slots
  localparam int WIN_LSB = GRP_IDX_W + 3;

  logic winHit;
  logic liveWord;
  logic [1:0] unusedLowBits;

  assign unusedLowBits = regAddr[1:0];
  assign winHit   = (regAddr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
  assign liveWord = winHit && regAddr[2];

  always_comb begin
    strb.wrHi   = regSel && regWr && liveWord;
    strb.rdLive = regSel && !regWr && liveWord;
    strb.rdZero = regSel && !regWr && !liveWord;
    strb.idx    = regAddr[WIN_LSB-1:3];
  end

endmodule

// File: rtl/irqmap_dpath.sv
module irqmap_dpath
  import irqmap_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int DATA_W = 32,
  localparam int IRQ_W = GRP_CNT * LINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              softRst,
  input  mapStrb_t          strb,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [IRQ_W-1:0]  irqIn,
  output logic [IRQ_W-1:0]  irqOut
);

  logic [GRP_CNT-1:0] enReg;
  logic [DATA_W-2:0]  unusedWdata;

  assign unusedWdata = regWdata[DATA_W-2:0];

  // Enable storage: device reset wins over a same-cycle write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enReg <= '0;
    end else if (softRst) begin
      enReg <= '0;
    end else if (strb.wrHi) begin
      enReg[strb.idx] <= regWdata[DATA_W-1];
    end
  end

  // Registered read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regRdata <= '0;
    end else if (strb.rdLive) begin
      regRdata <= {enReg[strb.idx], routeCode(strb.idx)};
    end else if (strb.rdZero) begin
      regRdata <= '0;
    end
  end

  // Per-group gate
  for (genvar g = 0; g < GRP_CNT; g++) begin : gGate
    assign irqOut[g*LINES +: LINES] = irqIn[g*LINES +: LINES] & {LINES{enReg[g]}};
  end

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrHi && !softRst |=> enReg[$past(strb.idx)] == $past(regWdata[DATA_W-1])); // R4
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.wrHi && !softRst |=> $stable(enReg)); // R6
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    softRst |=> irqOut == '0); // R9
  AST_CODE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rdLive |=> regRdata[DATA_W-2:0] == routeCode($past(strb.idx))); // R2
  AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rdZero |=> regRdata == '0); // R5

endmodule

// File: rtl/irq_map_gate.sv
module irq_map_gate
  import irqmap_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0C00,
  parameter int                LINES     = 4,
  parameter int                DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              softRst,
  input  logic              regSel,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [31:0]       irqIn,
  output logic [31:0]       irqOut
);

  mapStrb_t strb;

  irqmap_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) uCtrl (
    .regSel (regSel),
    .regWr  (regWr),
    .regAddr(regAddr),
    .strb   (strb)
  );

  irqmap_dpath #(.LINES(LINES), .DATA_W(DATA_W)) uDpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .softRst (softRst),
    .strb    (strb),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .irqIn   (irqIn),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/sim_irq_map_gate.sv
`timescale 1ns/1ps
module sim_irq_map_gate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        softRst = 1'b0;
  logic        regSel = 1'b0;
  logic        regWr = 1'b0;
  logic [15:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [31:0] irqIn = '0;
  logic [31:0] irqOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] enModel = '0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;  // 50 MHz

  irq_map_gate u0 (
    .clk(clk), .rst_n(rst_n), .softRst(softRst), .regSel(regSel), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .irqIn(irqIn), .irqOut(irqOut)
  );

  function automatic logic [31:0] codeOf(int g);
    return (32'h1F << 6) | (32'(g) << 2);
  endfunction

  function automatic logic [31:0] gateModel(logic [31:0] inp);
    logic [31:0] m;
    for (int n = 0; n < 32; n++) m[n] = inp[n] & enModel[n >> 2];
    return m;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: one-cycle strobes, launched on the falling edge
  task automatic doRead(logic [15:0] a, logic [31:0] exp, string tag);
    regSel = 1'b1; regWr = 1'b0; regAddr = a;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    regSel = 1'b0;
  endtask

  task automatic doWrite(logic [15:0] a, logic [31:0] d);
    regSel = 1'b1; regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regSel = 1'b0; regWr = 1'b0;
  endtask

  task automatic chkOut(string tag);
    check(tag, irqOut, gateModel(irqIn));
  endtask

  // Monitor: result appears in the cycle after the read strobe
  initial begin
    forever begin
      bit wasRd;
      @(posedge clk);
      wasRd = regSel && !regWr && rst_n;
      #5;
      if (wasRd) begin
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R3 actual unexpected read expected none");
        end else begin
          logic [31:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(t, regRdata, e);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    irqIn = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs low after reset", irqOut, 32'h0);

    // R2 / R1: initial contents, back-to-back reads (R3)
    for (int g = 0; g < 8; g++) doRead(16'h0C04 + 16'(g*8), codeOf(g), "R2 initial code R3");
    // R5: lower words read zero
    for (int g = 0; g < 8; g++) doRead(16'h0C00 + 16'(g*8), 32'h0, "R5 lower word zero");

    // R4: writes only touch bit 31
    doWrite(16'h0C14, 32'h8000_0000); enModel[2] = 1'b1;
    doRead(16'h0C14, 32'h8000_0000 | codeOf(2), "R4 enable set");
    doWrite(16'h0C2C, 32'hFFFF_FFFF); enModel[5] = 1'b1;
    doRead(16'h0C2C, 32'h8000_0000 | codeOf(5), "R4 code kept on ones");
    doWrite(16'h0C2C, 32'h7FFF_FFFF); enModel[5] = 1'b0;
    doRead(16'h0C2C, codeOf(5), "R4 enable cleared");
    chkOut("R8 group5 gated");

    // R10: enable visible the cycle after the write
    regSel = 1'b1; regWr = 1'b1; regAddr = 16'h0C04; regWdata = 32'h8000_0000;
    @(negedge clk);
    regSel = 1'b0; regWr = 1'b0; enModel[0] = 1'b1;
    check("R10 enable reaches output", irqOut, 32'h0000_0F0F);

    // R7 / R8: enable groups 0,3,7 (2 already on), varied patterns
    doWrite(16'h0C1C, 32'h8000_0000); enModel[3] = 1'b1;
    doWrite(16'h0C3C, 32'h8000_0000); enModel[7] = 1'b1;
    irqIn = 32'hA5A5_A5A5; @(negedge clk); chkOut("R7 pattern A5");
    irqIn = 32'h5A5A_5A5A; @(negedge clk); chkOut("R7 pattern 5A");
    irqIn = 32'h1234_5678; @(negedge clk); chkOut("R8 pattern mixed");
    irqIn = 32'h0F0F_00F0; @(negedge clk); chkOut("R8 pattern sparse");
    irqIn = 32'hFFFF_FFFF; @(negedge clk);
    check("R7 R8 all ones", irqOut, 32'hF000_FF0F);

    // R5: write to lower word ignored
    doWrite(16'h0C08, 32'h8000_0000);
    @(negedge clk); chkOut("R5 lower write no effect");
    doRead(16'h0C0C, codeOf(1), "R5 reg1 still off");

    // R6: unmapped writes and reads
    doWrite(16'h0C44, 32'h8000_0000);
    doWrite(16'h0BFC, 32'h8000_0000);
    doWrite(16'h1C0C, 32'h8000_0000);
    @(negedge clk); chkOut("R6 unmapped write no effect");
    doRead(16'h0C44, 32'h0, "R6 unmapped read");
    doRead(16'h1C14, 32'h0, "R6 alias read");
    doRead(16'h0C24, codeOf(4), "R6 reg4 still off");

    // R9: device reset, colliding with a write
    softRst = 1'b1;
    regSel = 1'b1; regWr = 1'b1; regAddr = 16'h0C0C; regWdata = 32'h8000_0000;
    @(negedge clk);
    softRst = 1'b0; regSel = 1'b0; regWr = 1'b0; enModel = '0;
    check("R9 outputs cleared", irqOut, 32'h0);
    for (int g = 0; g < 8; g++) doRead(16'h0C04 + 16'(g*8), codeOf(g), "R9 codes intact");

    repeat (3) @(negedge clk);
    check("R3 all reads answered", 32'(expQ.size()), 32'h0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule